// File: doc/BRIEF.md
# Palette Colour Lookup with Border and Cursor Overlay

This block holds the colour palette of a raster video pipeline. A processor programs it by single 32-bit word writes. The top six bits of each word select the target, and the low bits carry the value. There are sixteen logical colour slots, one border slot, three cursor slots and a small control register.

Each slot stores a 4-bit red, green and blue triple plus a supremacy flag. For every pixel clock the block takes a logical colour index, a border-active flag and a 2-bit cursor pixel value. One clock later it presents the chosen 12-bit colour and its supremacy flag.

The colour-depth setting decides how many index bits reach the logical palette. In the deepest mode, the upper index nibble bypasses the palette and leaves on a separate direct-colour output.

Top module: `vpal_lookup`

## Requirements
- R1: A write whose bits 31:26 hold a code n from 0 to 15 loads logical slot n with bits 12:0 of the word, laid out as red in bits 3:0, green in 7:4, blue in 11:8 and supremacy in bit 12. Bits 25:13 are not stored. On `rgb_out`, red is bits 3:0, green is bits 7:4 and blue is bits 11:8.
- R2: A write with code 16 loads the border slot with the same layout.
- R3: A write with code 17, 18 or 19 loads cursor slot 1, 2 or 3 respectively with the same layout.
- R4: A write with code 56 loads the colour-depth field from bits 3:2. The values 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel.
- R5: A write with any other code changes no slot and does not change the colour depth.
- R6: At 1, 2 and 4 bits per pixel, only the low 1, 2 or 4 index bits address the logical palette, and the higher index bits count as zero.
- R7: At 8 bits per pixel, index bits 3:0 address the logical palette and `direct_out` carries index bits 7:4. At every other depth, `direct_out` is zero.
- R8: A nonzero cursor pixel selects its cursor slot. Otherwise an active border flag selects the border slot. Otherwise the logical slot is selected.
- R9: The outputs are registered. Pixel inputs present before a clock edge appear on the outputs after that edge. A write made at one edge is seen by pixels sampled at the next edge.
- R10: Reset clears every slot, sets the colour depth to 1 bit per pixel, and drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_data | input | 32 | Write word: target code in 31:26, value below |
| pix_index | input | 8 | Logical colour index of the current pixel |
| border_act | input | 1 | Pixel lies in the border region |
| cursor_pix | input | 2 | Cursor pixel value, zero is transparent |
| rgb_out | output | 12 | Selected colour: blue, green, red from top to bottom |
| supreme_out | output | 1 | Supremacy flag of the selected slot |
| direct_out | output | 4 | Upper index nibble at 8 bits per pixel, else zero |

## Verification
The hardest state to reach from the ports is one where every slot holds a distinct value at the moment a rejected write arrives. Only then can a stray update to any slot show up.

The stimulus fills all twenty slots with distinct patterns and issues writes with unused codes. It then switches to 8 bits per pixel so that every logical slot can be read by its full index. After that it walks the border and every cursor value.

Random traffic then interleaves writes across all codes, including unused ones, with pixels at every depth and overlay combination.

// File: rtl/vpal_pkg.sv
package vpal_pkg;

   typedef enum logic [1:0] {
      DEPTH_1 = 2'd0,
      DEPTH_2 = 2'd1,
      DEPTH_4 = 2'd2,
      DEPTH_8 = 2'd3
   } depth_e;

   // number of index bits that a depth setting lets through
   function automatic int depth_bits(input depth_e d);
      case (d)
         DEPTH_1: return 1;
         DEPTH_2: return 2;
         DEPTH_4: return 4;
         default: return 8;
      endcase
   endfunction

endpackage

// File: rtl/vpal_decode.sv
module vpal_decode
   import vpal_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int CODE_W   = 6,
   parameter int NUM_LOG  = 16,
   parameter int NUM_CUR  = 3,
   parameter int ENT_W    = 13,
   parameter int CTRL_CODE = 56
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [WORD_W-1:0]          wr_data,
   output logic                       lg_we,
   output logic [$clog2(NUM_LOG)-1:0] lg_sel,
   output logic                       bd_we,
   output logic                       cs_we,
   output logic [$clog2(NUM_CUR+1)-1:0] cs_sel,
   output logic                       ctl_we,
   output logic [ENT_W-1:0]           ent_data,
   output depth_e                     depth_data
);
   localparam int LOG_BITS   = $clog2(NUM_LOG);
   localparam int CUR_BITS   = $clog2(NUM_CUR + 1);
   localparam int BORDER_CODE = NUM_LOG;
   localparam int CUR_LO     = NUM_LOG + 1;
   localparam int CUR_HI     = NUM_LOG + NUM_CUR;

   if (CUR_HI >= (1 << CODE_W)) begin : g_bad_codes
      $error("vpal_decode: cursor codes exceed code field");
   end
   if (CTRL_CODE <= CUR_HI || CTRL_CODE >= (1 << CODE_W)) begin : g_bad_ctrl
      $error("vpal_decode: control code collides or overflows");
   end
   if (ENT_W + CODE_W > WORD_W) begin : g_bad_word
      $error("vpal_decode: entry and code do not fit the word");
   end

   logic [CODE_W-1:0] code;
   logic [CODE_W-1:0] cur_off;
   logic [WORD_W-CODE_W-ENT_W-1:0] unused_mid;

   assign code       = wr_data[WORD_W-1 -: CODE_W];
   assign cur_off    = code - CODE_W'(NUM_LOG);
   assign unused_mid = wr_data[WORD_W-CODE_W-1:ENT_W];

   always_comb begin
      lg_we  = wr_en && (int'(code) < NUM_LOG);
      bd_we  = wr_en && (int'(code) == BORDER_CODE);
      cs_we  = wr_en && (int'(code) >= CUR_LO) && (int'(code) <= CUR_HI);
      ctl_we = wr_en && (int'(code) == CTRL_CODE);
      lg_sel = code[LOG_BITS-1:0];
      cs_sel = cur_off[CUR_BITS-1:0];
   end

   assign ent_data   = wr_data[ENT_W-1:0];
   assign depth_data = depth_e'(wr_data[3:2]);

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lg_we, bd_we, cs_we, ctl_we}));

endmodule

// File: rtl/vpal_regfile.sv
module vpal_regfile
   import vpal_pkg::*;
#(
   parameter int NUM_LOG = 16,
   parameter int NUM_CUR = 3,
   parameter int ENT_W   = 13
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         lg_we,
   input  logic [$clog2(NUM_LOG)-1:0]   lg_sel,
   input  logic                         bd_we,
   input  logic                         cs_we,
   input  logic [$clog2(NUM_CUR+1)-1:0] cs_sel,
   input  logic                         ctl_we,
   input  logic [ENT_W-1:0]             ent_data,
   input  depth_e                       depth_data,
   output logic [ENT_W-1:0]             lg_tab [NUM_LOG],
   output logic [ENT_W-1:0]             bd_ent,
   output logic [ENT_W-1:0]             cs_tab [NUM_CUR+1],
   output depth_e                       depth_q
);

   for (genvar k = 0; k < NUM_LOG; k++) begin : g_log
      always_ff @(posedge clk) begin
         if (!rst_n)                         lg_tab[k] <= '0;
         else if (lg_we && int'(lg_sel) == k) lg_tab[k] <= ent_data;
      end

      // R1
      lg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (lg_we && int'(lg_sel) == k) |=> lg_tab[k] == $past(ent_data));
      // R5
      lg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(lg_we && int'(lg_sel) == k) |=> $stable(lg_tab[k]));
   end

   // slot 0 is the transparent cursor value and never stores anything
   assign cs_tab[0] = '0;
   for (genvar c = 1; c <= NUM_CUR; c++) begin : g_cur
      always_ff @(posedge clk) begin
         if (!rst_n)                         cs_tab[c] <= '0;
         else if (cs_we && int'(cs_sel) == c) cs_tab[c] <= ent_data;
      end

      // R3
      cs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cs_we && int'(cs_sel) == c) |=> cs_tab[c] == $past(ent_data));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bd_ent  <= '0;
         depth_q <= DEPTH_1;
      end else begin
         if (bd_we)  bd_ent  <= ent_data;
         if (ctl_we) depth_q <= depth_data;
      end
   end

   // R2
   bd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bd_we |=> bd_ent == $past(ent_data));
   // R4
   depth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we |=> $stable(depth_q));

endmodule

// File: rtl/vpal_select.sv
module vpal_select
   import vpal_pkg::*;
#(
   parameter int NUM_LOG = 16,
   parameter int NUM_CUR = 3,
   parameter int ENT_W   = 13,
   parameter int IDX_W   = 8,
   parameter int CUR_W   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ENT_W-1:0]           lg_tab [NUM_LOG],
   input  logic [ENT_W-1:0]           bd_ent,
   input  logic [ENT_W-1:0]           cs_tab [NUM_CUR+1],
   input  depth_e                     depth_q,
   input  logic [IDX_W-1:0]           pix_index,
   input  logic                       border_act,
   input  logic [CUR_W-1:0]           cursor_pix,
   output logic [ENT_W-1:0]           ent_q,
   output logic [IDX_W-$clog2(NUM_LOG)-1:0] direct_q
);
   localparam int LOG_BITS = $clog2(NUM_LOG);
   localparam int DIR_W    = IDX_W - LOG_BITS;

   if (DIR_W < 1) begin : g_bad_idx
      $error("vpal_select: index must be wider than the palette address");
   end
   if (NUM_CUR != (1 << CUR_W) - 1) begin : g_bad_cur
      $error("vpal_select: cursor slots must match cursor pixel width");
   end

   logic [LOG_BITS-1:0] idx_mask;
   logic [LOG_BITS-1:0] lg_addr;
   logic [ENT_W-1:0]    pick;
   logic [DIR_W-1:0]    dir_next;
   logic [ENT_W-1:0]    cur_pick;

   always_comb begin
      for (int i = 0; i < LOG_BITS; i++) begin
         idx_mask[i] = (i < depth_bits(depth_q));
      end
      lg_addr  = pix_index[LOG_BITS-1:0] & idx_mask;
      cur_pick = cs_tab[cursor_pix];
      if (cursor_pix != '0)  pick = cur_pick;
      else if (border_act)   pick = bd_ent;
      else                   pick = lg_tab[lg_addr];
      dir_next = (depth_q == DEPTH_8) ? pix_index[IDX_W-1:LOG_BITS] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_q    <= '0;
         direct_q <= '0;
      end else begin
         ent_q    <= pick;
         direct_q <= dir_next;
      end
   end

   // R7
   direct_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_q != DEPTH_8) |=> direct_q == '0);
   // R8
   cursor_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cursor_pix != '0) |=> ent_q == $past(cur_pick));
   // R8
   border_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cursor_pix == '0 && border_act) |=> ent_q == $past(bd_ent));

endmodule

// File: rtl/vpal_lookup.sv
module vpal_lookup
   import vpal_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int CODE_W    = 6,
   parameter int CHAN_W    = 4,
   parameter int NUM_LOG   = 16,
   parameter int CUR_W     = 2,
   parameter int IDX_W     = 8,
   parameter int CTRL_CODE = 56,
   localparam int NUM_CUR  = (1 << CUR_W) - 1,
   localparam int RGB_W    = 3 * CHAN_W,
   localparam int ENT_W    = RGB_W + 1,
   localparam int DIR_W    = IDX_W - $clog2(NUM_LOG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  pix_index,
   input  logic              border_act,
   input  logic [CUR_W-1:0]  cursor_pix,
   output logic [RGB_W-1:0]  rgb_out,
   output logic              supreme_out,
   output logic [DIR_W-1:0]  direct_out
);
   localparam int LOG_BITS = $clog2(NUM_LOG);
   localparam int CUR_BITS = $clog2(NUM_CUR + 1);

   if (NUM_LOG != (1 << LOG_BITS)) begin : g_bad_log
      $error("vpal_lookup: logical slot count must be a power of two");
   end

   logic                 lg_we, bd_we, cs_we, ctl_we;
   logic [LOG_BITS-1:0]  lg_sel;
   logic [CUR_BITS-1:0]  cs_sel;
   logic [ENT_W-1:0]     ent_data;
   depth_e               depth_data, depth_q;
   logic [ENT_W-1:0]     lg_tab [NUM_LOG];
   logic [ENT_W-1:0]     cs_tab [NUM_CUR+1];
   logic [ENT_W-1:0]     bd_ent;
   logic [ENT_W-1:0]     ent_q;

   vpal_decode #(
      .WORD_W(WORD_W), .CODE_W(CODE_W), .NUM_LOG(NUM_LOG),
      .NUM_CUR(NUM_CUR), .ENT_W(ENT_W), .CTRL_CODE(CTRL_CODE)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .lg_we(lg_we), .lg_sel(lg_sel), .bd_we(bd_we), .cs_we(cs_we),
      .cs_sel(cs_sel), .ctl_we(ctl_we), .ent_data(ent_data),
      .depth_data(depth_data)
   );

   vpal_regfile #(
      .NUM_LOG(NUM_LOG), .NUM_CUR(NUM_CUR), .ENT_W(ENT_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .lg_we(lg_we), .lg_sel(lg_sel),
      .bd_we(bd_we), .cs_we(cs_we), .cs_sel(cs_sel), .ctl_we(ctl_we),
      .ent_data(ent_data), .depth_data(depth_data),
      .lg_tab(lg_tab), .bd_ent(bd_ent), .cs_tab(cs_tab), .depth_q(depth_q)
   );

   vpal_select #(
      .NUM_LOG(NUM_LOG), .NUM_CUR(NUM_CUR), .ENT_W(ENT_W),
      .IDX_W(IDX_W), .CUR_W(CUR_W)
   ) u_sel (
      .clk(clk), .rst_n(rst_n), .lg_tab(lg_tab), .bd_ent(bd_ent),
      .cs_tab(cs_tab), .depth_q(depth_q), .pix_index(pix_index),
      .border_act(border_act), .cursor_pix(cursor_pix),
      .ent_q(ent_q), .direct_q(direct_out)
   );

   assign rgb_out     = ent_q[RGB_W-1:0];
   assign supreme_out = ent_q[ENT_W-1];

   // R10
   reset_zero_chk: assert property (@(posedge clk)
      !rst_n |=> (rgb_out == '0 && !supreme_out && direct_out == '0));

endmodule

// File: tb/test_vpal_lookup.sv
`timescale 1ns/1ps
module test_vpal_lookup;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [7:0]  pix_index = '0;
   logic        border_act = 1'b0;
   logic [1:0]  cursor_pix = '0;
   logic [11:0] rgb_out;
   logic        supreme_out;
   logic [3:0]  direct_out;

   int checks = 0;
   int errors = 0;

   // slots 0..15 logical, 16 border, 17..19 cursor 1..3
   logic [12:0] m_ent [20];
   logic [1:0]  m_depth;

   always #10 clk = ~clk;

   vpal_lookup i_vpal_lookup (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .pix_index(pix_index), .border_act(border_act), .cursor_pix(cursor_pix),
      .rgb_out(rgb_out), .supreme_out(supreme_out), .direct_out(direct_out)
   );

   function automatic logic [16:0] expect_out(input logic [7:0] idx,
                                              input logic bd,
                                              input logic [1:0] cur);
      logic [12:0] e;
      logic [3:0]  a;
      logic [3:0]  d;
      case (m_depth)
         2'd0:    a = {3'b000, idx[0]};
         2'd1:    a = {2'b00, idx[1:0]};
         default: a = idx[3:0];
      endcase
      if (cur != 2'd0)  e = m_ent[16 + int'(cur)];
      else if (bd)      e = m_ent[16];
      else              e = m_ent[a];
      d = (m_depth == 2'd3) ? idx[7:4] : 4'h0;
      return {d, e};
   endfunction

   task automatic compare(input string req, input logic [16:0] exp);
      logic [16:0] act;
      act = {direct_out, supreme_out, rgb_out};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [31:0] w);
      int code;
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = w;
      @(negedge clk);
      wr_en   = 1'b0;
      code = int'(w[31:26]);
      if (code < 20)       m_ent[code] = w[12:0];
      else if (code == 56) m_depth = w[3:2];
   endtask

   task automatic do_pix(input string req, input logic [7:0] idx,
                         input logic bd, input logic [1:0] cur);
      logic [16:0] exp;
      @(negedge clk);
      pix_index  = idx;
      border_act = bd;
      cursor_pix = cur;
      exp = expect_out(idx, bd, cur);
      @(negedge clk);
      compare(req, exp);
   endtask

   function automatic logic [31:0] mk(input int code, input logic [12:0] v);
      return {code[5:0], 13'h0, v};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int seed_v;
      logic [16:0] held;
      seed_v = $urandom(32'h5EED);
      for (int i = 0; i < 20; i++) m_ent[i] = '0;
      m_depth = 2'd0;

      // R10: outputs stay zero while reset is held
      pix_index = 8'hFF; border_act = 1'b1; cursor_pix = 2'd2;
      repeat (3) @(negedge clk);
      compare("R10 reset outputs", 17'h0);
      rst_n = 1'b1;
      do_pix("R10 cleared logical", 8'h01, 1'b0, 2'd0);
      do_pix("R10 cleared cursor", 8'h01, 1'b0, 2'd3);

      // fill every slot with a distinct pattern
      for (int k = 0; k < 16; k++) do_write(mk(k, 13'h0111 * k[12:0] ^ {k[0], 12'h5A3}));
      do_write(mk(16, 13'h1ABC));
      do_write(mk(17, 13'h0123));
      do_write(mk(18, 13'h1456));
      do_write(mk(19, 13'h0789));

      // R6: depth masking
      do_pix("R6 1bpp high bits dropped", 8'hFE, 1'b0, 2'd0);
      do_pix("R6 1bpp bit0", 8'hFF, 1'b0, 2'd0);
      do_write(mk(56, 13'h0004));
      do_pix("R4 R6 2bpp", 8'hFE, 1'b0, 2'd0);
      do_write(mk(56, 13'h0008));
      do_pix("R4 R6 4bpp", 8'hAB, 1'b0, 2'd0);
      do_pix("R7 direct zero at 4bpp", 8'hF3, 1'b0, 2'd0);
      do_write(mk(56, 13'h000C));
      do_pix("R4 R7 8bpp direct", 8'hAB, 1'b0, 2'd0);

      // R8: priority
      do_pix("R2 R8 border", 8'h35, 1'b1, 2'd0);
      do_pix("R3 R8 cursor1 over border", 8'h35, 1'b1, 2'd1);
      do_pix("R3 R8 cursor2", 8'h35, 1'b0, 2'd2);
      do_pix("R3 R8 cursor3", 8'h35, 1'b1, 2'd3);

      // R1: upper value bits are not stored
      do_write({6'd5, 13'h1FFF, 13'h0A5A});
      do_pix("R1 upper bits dropped", 8'h05, 1'b0, 2'd0);

      // R5: unused codes touch nothing
      do_write(mk(20, 13'h1FFF));
      do_write(mk(40, 13'h1FFF));
      do_write({6'd63, 26'h3FFFFFF});
      do_write({6'd57, 26'h0000000});
      for (int k = 0; k < 16; k++) do_pix("R5 logical kept", k[7:0], 1'b0, 2'd0);
      do_pix("R5 border kept", 8'h00, 1'b1, 2'd0);
      for (int c = 1; c < 4; c++) do_pix("R5 cursor kept", 8'h00, 1'b0, c[1:0]);
      do_pix("R5 depth kept", 8'hC9, 1'b0, 2'd0);

      // R9: a write is seen by the next pixel, and the output lags one edge
      do_write(mk(7, 13'h1E1E));
      do_pix("R9 write then read", 8'h07, 1'b0, 2'd0);
      held = expect_out(8'h07, 1'b0, 2'd0);
      @(negedge clk);
      pix_index = 8'h02;
      #5;
      compare("R9 output holds before edge", held);
      @(negedge clk);
      compare("R9 output after edge", expect_out(8'h02, 1'b0, 2'd0));

      // random traffic
      for (int n = 0; n < 600; n++) begin
         int sel;
         sel = int'($urandom % 5);
         if (sel == 0) begin
            int code;
            int pick;
            pick = int'($urandom % 8);
            if (pick < 5)       code = int'($urandom % 20);
            else if (pick == 5) code = 56;
            else                code = 20 + int'($urandom % 44);
            do_write({code[5:0], 26'($urandom)});
         end else begin
            logic [1:0] cur;
            cur = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
            do_pix("R6 R7 R8 random", 8'($urandom), 1'($urandom % 4 == 0), cur);
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule